// File: doc/BRIEF.md
# Legacy-Bus Cycle Strobe Sequencer

This block sits between a 32-bit processor's bus pins and an older, slower shared backplane bus. The processor starts every bus cycle with a one-clock address strobe. When a legacy-bus cycle is selected, the block captures the three cycle-status bits at that strobe. It turns them into a cycle kind: memory read, memory write, I/O read, I/O write, interrupt acknowledge or halt. It then plays out a fixed sequence of backplane control strobes. Cycles aimed at the fast private port leave `legacy_sel` low, and the block ignores them.

Each legacy cycle runs through four phases. It opens with a one-clock start phase, where the sync and status-valid strobes are high. A strobe phase follows and lasts `wait_cfg`+1 clocks. The cycle ends with one ready clock, in which ready is returned to the processor. The write strobe is timed on its own: it rises one clock after the cycle starts and falls before the ready clock, so it is gone before the processor can move the address. Write data stays driven for one clock after the write strobe falls. The processor is told not to pipeline its next address while a legacy cycle is in flight. A 32-bit transfer reaches the block as two separate 16-bit cycles issued back to back.

There is no data stream here, so there is no valid/ready handshake. All pins are plain control levels, and the processor gets no back-pressure beyond the ready pulse.

Top module: `bcs_top`

## Requirements
- R1: While reset is held, every strobe, every cycle-kind output and `cpu_ready` are low, and `pipe_ok` is high.
- R2: A cycle starts only when `cpu_ads` and `legacy_sel` are both high in an idle clock. An address strobe with `legacy_sel` low does nothing. An address strobe that arrives during a cycle does nothing.
- R3: The status bits are read as {`cpu_mio`,`cpu_dc`,`cpu_wr`}. The codes map as follows: 000 is interrupt acknowledge, 010 is I/O read, 011 is I/O write, 100 and 110 are memory read, 111 is memory write and 101 is halt. Code 001 gives no kind. The matching `cyc_*` output is high from the start clock through the ready clock, and no more than one of them is high at a time.
- R4: `bus_sync` and `bus_stval` are high in the start clock only. The start clock is the clock after the one in which the address strobe was taken.
- R5: For write kinds, `bus_wr` is high for exactly the `wait_cfg`+1 clocks of the strobe phase. It is low in the start clock and in the ready clock. It never rises for other kinds.
- R6: For read kinds and interrupt acknowledge, `bus_dbin` is high from the first strobe-phase clock through the ready clock.
- R7: `bus_inta` is high in exactly the clocks where `bus_dbin` is high during an interrupt-acknowledge cycle. It is low in all other clocks.
- R8: For write kinds, `wdata_oe` is high during the whole write strobe and for one further clock, which is the ready clock.
- R9: `cpu_ready` is high for exactly one clock per cycle. That clock is the (`wait_cfg`+3)th clock of the cycle, counting the start clock as the first.
- R10: The wait count is sampled with the address strobe. Changes on `wait_cfg` or on the status bits later in the cycle have no effect on it.
- R11: `pipe_ok` is low from the start clock through the ready clock and high in every idle clock.
- R12: An address strobe given in the clock right after the ready clock starts a new cycle. That cycle's status bits and wait count are taken fresh, as for the second half of a 32-bit transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ads | input | 1 | Address strobe, one clock per processor bus cycle |
| cpu_mio | input | 1 | Status: memory (1) or I/O (0) |
| cpu_dc | input | 1 | Status: data (1) or control/code (0) |
| cpu_wr | input | 1 | Status: write (1) or read (0) |
| legacy_sel | input | 1 | High when the cycle targets the legacy bus |
| wait_cfg | input | WAIT_W | Wait states added to the strobe phase |
| cpu_ready | output | 1 | One-clock ready back to the processor |
| pipe_ok | output | 1 | High when address pipelining may be used |
| bus_sync | output | 1 | Cycle-start sync strobe |
| bus_stval | output | 1 | Status-valid strobe |
| bus_dbin | output | 1 | Data-in strobe for reads and acknowledge |
| bus_wr | output | 1 | Delayed write strobe |
| wdata_oe | output | 1 | Write data drive enable |
| bus_inta | output | 1 | Interrupt-acknowledge strobe |
| cyc_memr | output | 1 | Cycle kind: memory read |
| cyc_memw | output | 1 | Cycle kind: memory write |
| cyc_ior | output | 1 | Cycle kind: I/O read |
| cyc_iow | output | 1 | Cycle kind: I/O write |
| cyc_inta | output | 1 | Cycle kind: interrupt acknowledge |
| cyc_halt | output | 1 | Cycle kind: halt |

## Verification
The hardest case to reach from the ports is a change of inputs after a cycle has been accepted. This covers a second address strobe landing in the strobe phase, and `wait_cfg` or the status bits changing the clock after capture. The stimulus sets up both on purpose. Every cycle scrambles `wait_cfg`, the status bits and `legacy_sel` right after the address strobe. Random cycles also pulse a second address strobe in the first strobe-phase clock. Cycles are issued back to back with no spare idle clock, which brings in the second-half case of a split 32-bit transfer.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_START  = 2'd1,
    PH_STROBE = 2'd2,
    PH_LAST   = 2'd3
  } phase_e;

  typedef struct packed {
    logic memr;
    logic memw;
    logic ior;
    logic iow;
    logic inta;
    logic halt;
  } kind_t;

  function automatic kind_t decode_status(input logic mio, input logic dc, input logic wr);
    kind_t k;
    k = '0;
    unique case ({mio, dc, wr})
      3'b000:         k.inta = 1'b1;
      3'b010:         k.ior  = 1'b1;
      3'b011:         k.iow  = 1'b1;
      3'b100, 3'b110: k.memr = 1'b1;
      3'b111:         k.memw = 1'b1;
      3'b101:         k.halt = 1'b1;
      default:        k = '0;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/bcs_status_latch.sv
module bcs_status_latch
  import bcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture,
  input  logic  mio,
  input  logic  dc,
  input  logic  wr,
  output kind_t kind
);

  always_ff @(posedge clk) begin
    if (!rst_n)       kind <= '0;
    else if (capture) kind <= decode_status(mio, dc, wr);
  end

  p_kind_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kind));

endmodule

// File: rtl/bcs_phase_ctl.sv
module bcs_phase_ctl
  import bcs_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads,
  input  logic              sel,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              capture,
  output phase_e            phase
);

  logic [WAIT_W-1:0] wait_left;

  assign capture = (phase == PH_IDLE) && ads && sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      wait_left <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (capture) begin
          phase     <= PH_START;
          wait_left <= wait_cfg;
        end
        PH_START:  phase <= PH_STROBE;
        PH_STROBE: begin
          if (wait_left == '0) phase <= PH_LAST;
          else                 wait_left <= wait_left - 1'b1;
        end
        PH_LAST:   phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  p_start_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_START) |-> $past(ads && sel));

  p_busy_ads_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> (phase != PH_START));

  p_last_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LAST) |=> (phase == PH_IDLE));

endmodule

// File: rtl/bcs_strobe_map.sv
module bcs_strobe_map
  import bcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  kind_t  kind,
  output logic   cpu_ready,
  output logic   pipe_ok,
  output logic   bus_sync,
  output logic   bus_stval,
  output logic   bus_dbin,
  output logic   bus_wr,
  output logic   wdata_oe,
  output logic   bus_inta,
  output kind_t  kind_out
);

  logic busy, in_strobe, strobe_or_last, is_write, is_input;

  always_comb begin
    busy           = (phase != PH_IDLE);
    in_strobe      = (phase == PH_STROBE);
    strobe_or_last = in_strobe || (phase == PH_LAST);
    is_write       = kind.memw || kind.iow;
    is_input       = kind.memr || kind.ior || kind.inta;

    bus_sync  = (phase == PH_START);
    bus_stval = (phase == PH_START);
    cpu_ready = (phase == PH_LAST);
    pipe_ok   = !busy;
    bus_wr    = in_strobe && is_write;
    wdata_oe  = strobe_or_last && is_write;
    bus_dbin  = strobe_or_last && is_input;
    bus_inta  = strobe_or_last && kind.inta;
    kind_out  = busy ? kind : '0;
  end

  p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_sync_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sync |=> !bus_sync);

  p_wr_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sync |=> (bus_wr || !kind_out.memw) && (bus_wr || !kind_out.iow));

  p_wr_gone_at_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_wr);

  p_oe_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr) |-> wdata_oe);

  p_inta_with_dbin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_inta |-> bus_dbin);

  p_no_pipe_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sync || bus_dbin || bus_wr || cpu_ready) |-> !pipe_ok);

endmodule

// File: rtl/bcs_top.sv
module bcs_top
  import bcs_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ads,
  input  logic              cpu_mio,
  input  logic              cpu_dc,
  input  logic              cpu_wr,
  input  logic              legacy_sel,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              cpu_ready,
  output logic              pipe_ok,
  output logic              bus_sync,
  output logic              bus_stval,
  output logic              bus_dbin,
  output logic              bus_wr,
  output logic              wdata_oe,
  output logic              bus_inta,
  output logic              cyc_memr,
  output logic              cyc_memw,
  output logic              cyc_ior,
  output logic              cyc_iow,
  output logic              cyc_inta,
  output logic              cyc_halt
);

  logic   capture;
  phase_e phase;
  kind_t  kind, kind_vis;

  bcs_phase_ctl #(.WAIT_W(WAIT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .ads      (cpu_ads),
    .sel      (legacy_sel),
    .wait_cfg (wait_cfg),
    .capture  (capture),
    .phase    (phase)
  );

  bcs_status_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .mio     (cpu_mio),
    .dc      (cpu_dc),
    .wr      (cpu_wr),
    .kind    (kind)
  );

  bcs_strobe_map u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .kind      (kind),
    .cpu_ready (cpu_ready),
    .pipe_ok   (pipe_ok),
    .bus_sync  (bus_sync),
    .bus_stval (bus_stval),
    .bus_dbin  (bus_dbin),
    .bus_wr    (bus_wr),
    .wdata_oe  (wdata_oe),
    .bus_inta  (bus_inta),
    .kind_out  (kind_vis)
  );

  assign cyc_memr = kind_vis.memr;
  assign cyc_memw = kind_vis.memw;
  assign cyc_ior  = kind_vis.ior;
  assign cyc_iow  = kind_vis.iow;
  assign cyc_inta = kind_vis.inta;
  assign cyc_halt = kind_vis.halt;

endmodule

// File: tb/test_bcs_top.sv
module test_bcs_top;

  localparam int WAIT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_ads = 1'b0, cpu_mio = 1'b0, cpu_dc = 1'b0, cpu_wr = 1'b0, legacy_sel = 1'b0;
  logic [WAIT_W-1:0] wait_cfg = '0;
  logic cpu_ready, pipe_ok, bus_sync, bus_stval, bus_dbin, bus_wr, wdata_oe, bus_inta;
  logic cyc_memr, cyc_memw, cyc_ior, cyc_iow, cyc_inta, cyc_halt;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  bcs_top #(.WAIT_W(WAIT_W)) i_bcs_top (
    .clk(clk), .rst_n(rst_n), .cpu_ads(cpu_ads), .cpu_mio(cpu_mio), .cpu_dc(cpu_dc),
    .cpu_wr(cpu_wr), .legacy_sel(legacy_sel), .wait_cfg(wait_cfg),
    .cpu_ready(cpu_ready), .pipe_ok(pipe_ok), .bus_sync(bus_sync), .bus_stval(bus_stval),
    .bus_dbin(bus_dbin), .bus_wr(bus_wr), .wdata_oe(wdata_oe), .bus_inta(bus_inta),
    .cyc_memr(cyc_memr), .cyc_memw(cyc_memw), .cyc_ior(cyc_ior), .cyc_iow(cyc_iow),
    .cyc_inta(cyc_inta), .cyc_halt(cyc_halt)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, got, exp);
    end
  endtask

  // Kind vector order {memr, memw, ior, iow, inta, halt}
  function automatic logic [5:0] exp_kind(input logic [2:0] code);
    case (code)
      3'b000:         return 6'b000010;
      3'b010:         return 6'b001000;
      3'b011:         return 6'b000100;
      3'b100, 3'b110: return 6'b100000;
      3'b111:         return 6'b010000;
      3'b101:         return 6'b000001;
      default:        return 6'b000000;
    endcase
  endfunction

  function automatic logic code_is_wr(input logic [2:0] code);
    return (code == 3'b011) || (code == 3'b111);
  endfunction

  function automatic logic code_is_in(input logic [2:0] code);
    return (code == 3'b000) || (code == 3'b010) || (code == 3'b100) || (code == 3'b110);
  endfunction

  task automatic check_clock(input logic [2:0] code, input int w, input int k);
    logic strobe_ph, any_ph, last_ph;
    strobe_ph = (k >= 2) && (k <= w + 2);
    last_ph   = (k == w + 3);
    any_ph    = strobe_ph || last_ph;
    check("R4 sync/stval", {6'b0, bus_sync, bus_stval}, {6'b0, k == 1, k == 1});
    check("R5 write strobe", {7'b0, bus_wr}, {7'b0, code_is_wr(code) && strobe_ph});
    check("R6 data-in", {7'b0, bus_dbin}, {7'b0, code_is_in(code) && any_ph});
    check("R7 inta strobe", {7'b0, bus_inta}, {7'b0, (code == 3'b000) && any_ph});
    check("R8 write data enable", {7'b0, wdata_oe}, {7'b0, code_is_wr(code) && any_ph});
    check("R9 R10 ready timing", {7'b0, cpu_ready}, {7'b0, last_ph});
    check("R11 pipelining off", {7'b0, pipe_ok}, 8'b0);
    check("R3 kind decode", {2'b0, cyc_memr, cyc_memw, cyc_ior, cyc_iow, cyc_inta, cyc_halt},
          {2'b0, exp_kind(code)});
  endtask

  // One legacy cycle; starts at the clock right after the previous one ends (R12)
  task automatic run_cycle(input logic [2:0] code, input int w, input bit poke);
    @(negedge clk);
    check("R2 R11 idle before strobe", {5'b0, bus_sync, cpu_ready, pipe_ok}, 8'b001);
    cpu_ads = 1'b1; legacy_sel = 1'b1;
    {cpu_mio, cpu_dc, cpu_wr} = code;
    wait_cfg = WAIT_W'(w);
    for (int k = 1; k <= w + 3; k++) begin
      @(negedge clk);
      if (k == 1) begin
        // R10: scramble the inputs after capture
        cpu_ads = 1'b0;
        wait_cfg = WAIT_W'($urandom);
        {cpu_mio, cpu_dc, cpu_wr} = 3'($urandom);
        legacy_sel = 1'($urandom);
      end
      check_clock(code, w, k);
      if (poke && k == 2) begin
        cpu_ads = 1'b1; legacy_sel = 1'b1;  // R2: strobe while busy
      end
      if (k == 3) cpu_ads = 1'b0;
    end
    cpu_ads = 1'b0;
  endtask

  task automatic stray_ads();
    @(negedge clk);
    cpu_ads = 1'b1; legacy_sel = 1'b0;
    {cpu_mio, cpu_dc, cpu_wr} = 3'b111;
    @(negedge clk);
    cpu_ads = 1'b0;
    check("R2 unselected strobe ignored", {6'b0, bus_sync, pipe_ok}, 8'b01);
    @(negedge clk);
    check("R2 unselected strobe ignored later", {5'b0, bus_wr, cpu_ready, pipe_ok}, 8'b001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL R9 watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    check("R1 reset strobes", {bus_sync, bus_stval, bus_dbin, bus_wr, wdata_oe, bus_inta, cpu_ready, pipe_ok},
          8'b00000001);
    check("R1 reset kinds", {2'b0, cyc_memr, cyc_memw, cyc_ior, cyc_iow, cyc_inta, cyc_halt}, 8'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: every code, minimum and maximum waits
    for (int c = 0; c < 8; c++) begin
      run_cycle(3'(c), 0, 1'b0);
      run_cycle(3'(c), (1 << WAIT_W) - 1, 1'b1);
    end
    stray_ads();
    // R12: split 32-bit write then read back to back
    run_cycle(3'b111, 1, 1'b0);
    run_cycle(3'b111, 1, 1'b0);
    run_cycle(3'b110, 0, 1'b0);
    run_cycle(3'b110, 0, 1'b0);

    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 7) == 0) stray_ads();
      if ($urandom_range(0, 3) == 0) @(negedge clk);
      run_cycle(3'($urandom), int'($urandom_range(0, (1 << WAIT_W) - 1)), 1'($urandom));
    end

    @(negedge clk);
    check("R11 idle after run", {7'b0, pipe_ok}, 8'b1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule